// File: doc/BRIEF.md
# Coherent Digital Lock-In I/Q Detector

This block recovers the amplitude and phase of a weak return signal at one known frequency. It generates that frequency itself. A phase-accumulator oscillator produces a cosine sample on every clock, and that sample leaves the block to drive an external DAC, which modulates the sensor. The same cosine, together with a matching sine, multiplies each incoming signed ADC sample. This moves the return at the reference frequency down to DC as an in-phase and quadrature pair.

The two products are summed over a programmable number of clocks. At the end of each window the block presents the sums as one complex estimate, with a one-clock strobe. The excitation, the sampling and the detection all run from one clock, so the detector stays coherent with its own drive and needs no loop that locks to the input. With a 20 MHz clock and a window of 20,000,000 samples, one estimate appears per second, which gives a passband of about 1 Hz around the reference.

Top module: `lockin_iq_demod`

## Requirements
- R1: While rst_ni is low, dac_o, iq_i_o and iq_q_o are zero and iq_valid_o is low.
- R2: A 32-bit phase register starts at zero after reset and grows by the active tuning word on every clock, wrapping modulo 2^32. Its top 10 bits form the lookup address.
- R3: The lookup address splits into a quadrant (bits 9:8) and an index k (bits 7:0). Let T[k] = trunc(32767*sin((pi/2)*(k+0.5)/256)). Sine by quadrant 0..3 is T[k], T[255-k], -T[k], -T[255-k]. Cosine by quadrant 0..3 is T[255-k], -T[k], -T[255-k], T[k].
- R4: dac_o shows the cosine of a phase value two clocks after that phase value is held in the phase register. The ADC sample taken on the first of those clocks is mixed with the same phase value.
- R5: Each ADC sample, read as 12-bit two's complement, is multiplied by the matching cosine (I path) and sine (Q path) as a signed 28-bit product. A product enters its sum one clock after it is formed.
- R6: A window ends on the clock where the sample count plus one reaches the active ratio. On that clock the I and Q sums, including that clock's products, appear on iq_i_o and iq_q_o, and iq_valid_o is high for the following cycle only (for ratios above 1). The sums restart from zero with the next product, and no product is lost.
- R7: The 56-bit signed sums hold full-scale input over any test window without wrapping.
- R8: tune_word_i and dec_ratio_i are sampled only on a window-ending clock. A change between boundaries has no effect on dac_o or on the window length. A ratio of 0 behaves as a ratio of 1.
- R9: After reset the active tuning word is DEF_TUNE and the active ratio is DEF_RATIO, until the first boundary loads the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock for oscillator, DAC, ADC and detector |
| rst_ni | input | 1 | Asynchronous reset, active low |
| adc_i | input | 12 | Signed ADC sample, one per clock |
| tune_word_i | input | 32 | Phase increment, loaded at a window boundary |
| dec_ratio_i | input | 32 | Samples per window, loaded at a window boundary |
| dac_o | output | 16 | Signed cosine reference for the DAC |
| iq_i_o | output | 56 | In-phase window sum |
| iq_q_o | output | 56 | Quadrature window sum |
| iq_valid_o | output | 1 | One-clock strobe marking a new I/Q pair |

## Verification
The bench keeps the default datapath widths and the default tuning word, but sets DEF_RATIO to 24. The first windows after reset therefore close within a few dozen clocks instead of after twenty million, and the reset defaults of R9 can be observed. Ratios of 0 and 1 are driven to reach back-to-back strobes. A long full-scale window with a quarter-cycle tuning word visits every quadrant and the table ends. Random tuning words and ratios, changed mid-window, show that loads happen only at boundaries.

// File: rtl/lockin_pkg.sv
package lockin_pkg;
  typedef enum logic [1:0] {QD_0, QD_1, QD_2, QD_3} quad_e;
  localparam real HALF_PI = 1.5707963267948966;
endpackage

// File: rtl/lockin_nco.sv
module lockin_nco
  import lockin_pkg::*;
#(
  parameter int unsigned PHASE_W  = 32,
  parameter int unsigned LUT_AW   = 10,
  parameter int unsigned REF_W    = 16,
  parameter logic [PHASE_W-1:0] DEF_TUNE = 33071248
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      load_i,
  input  logic [PHASE_W-1:0]        tune_word_i,
  output logic signed [REF_W-1:0]   cos_o,
  output logic signed [REF_W-1:0]   sin_o
);
  localparam int unsigned QAW = LUT_AW - 2;
  localparam int unsigned QN  = 1 << QAW;
  localparam int          AMP = (1 << (REF_W - 1)) - 1;
  localparam logic signed [REF_W-1:0] REF_MIN = {1'b1, {(REF_W-1){1'b0}}};

  logic signed [REF_W-1:0] qtab [QN];

  // quarter-wave table, sampled at half-step offsets so both ends mirror exactly
  for (genvar g = 0; g < QN; g++) begin : g_qtab
    localparam real ANG = HALF_PI * (real'(g) + 0.5) / real'(QN);
    localparam int  VAL = $rtoi(real'(AMP) * $sin(ANG));
    assign qtab[g] = REF_W'(VAL);
  end

  logic [PHASE_W-1:0] phase_q, tw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      tw_q    <= DEF_TUNE;
    end else begin
      phase_q <= phase_q + tw_q;
      if (load_i) tw_q <= tune_word_i;
    end
  end

  logic [LUT_AW-1:0]       addr;
  logic [QAW-1:0]          idx;
  quad_e                   quad;
  logic signed [REF_W-1:0] fwd, rev, sin_d, cos_d;

  assign addr = phase_q[PHASE_W-1 -: LUT_AW];
  assign idx  = addr[QAW-1:0];
  assign quad = quad_e'(addr[LUT_AW-1 -: 2]);
  assign fwd  = qtab[idx];
  assign rev  = qtab[~idx];

  always_comb begin
    unique case (quad)
      QD_0: begin sin_d = fwd;  cos_d = rev;  end
      QD_1: begin sin_d = rev;  cos_d = -fwd; end
      QD_2: begin sin_d = -fwd; cos_d = -rev; end
      default: begin sin_d = -rev; cos_d = fwd; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cos_o <= '0;
      sin_o <= '0;
    end else begin
      cos_o <= cos_d;
      sin_o <= sin_d;
    end
  end

  // symmetric table: the most negative code never appears
  assert_ref_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cos_o != REF_MIN) && (sin_o != REF_MIN));

  // tuning word only moves on a boundary load
  assert_tune_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(tw_q));
endmodule

// File: rtl/lockin_mixer.sv
module lockin_mixer #(
  parameter int unsigned ADC_W  = 12,
  parameter int unsigned REF_W  = 16,
  parameter int unsigned PROD_W = ADC_W + REF_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [ADC_W-1:0]  adc_i,
  input  logic signed [REF_W-1:0]  cos_i,
  input  logic signed [REF_W-1:0]  sin_i,
  output logic signed [REF_W-1:0]  dac_o,
  output logic signed [PROD_W-1:0] prod_i_o,
  output logic signed [PROD_W-1:0] prod_q_o
);
  logic signed [ADC_W-1:0]  adc_q;
  logic signed [PROD_W-1:0] adc_x, cos_x, sin_x;

  assign adc_x = PROD_W'(adc_q);
  assign cos_x = PROD_W'(cos_i);
  assign sin_x = PROD_W'(sin_i);

  // adc_q sits in the same stage as the lookup register; dac_o in the product stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      adc_q    <= '0;
      dac_o    <= '0;
      prod_i_o <= '0;
      prod_q_o <= '0;
    end else begin
      adc_q    <= adc_i;
      dac_o    <= cos_i;
      prod_i_o <= adc_x * cos_x;
      prod_q_o <= adc_x * sin_x;
    end
  end

  // I product and DAC code come from the same phase value
  assert_dac_aligned_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prod_i_o != '0) |-> (dac_o != '0));
endmodule

// File: rtl/lockin_dump.sv
module lockin_dump #(
  parameter int unsigned PROD_W = 28,
  parameter int unsigned ACC_W  = 56,
  parameter int unsigned CNT_W  = 32,
  parameter logic [CNT_W-1:0] DEF_RATIO = 20000000
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [PROD_W-1:0] prod_i_i,
  input  logic signed [PROD_W-1:0] prod_q_i,
  input  logic [CNT_W-1:0]         ratio_i,
  output logic                     boundary_o,
  output logic signed [ACC_W-1:0]  sum_i_o,
  output logic signed [ACC_W-1:0]  sum_q_o,
  output logic                     valid_o
);
  localparam int unsigned NCH = 2;

  logic [CNT_W-1:0] cnt_q, ratio_q;
  logic [CNT_W:0]   cnt_next;
  logic signed [PROD_W-1:0] prod [NCH];
  logic signed [ACC_W-1:0]  acc_q [NCH];
  logic signed [ACC_W-1:0]  out_q [NCH];

  assign prod[0]    = prod_i_i;
  assign prod[1]    = prod_q_i;
  assign cnt_next   = {1'b0, cnt_q} + (CNT_W+1)'(1);
  assign boundary_o = cnt_next >= {1'b0, ratio_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ratio_q <= DEF_RATIO;
      valid_o <= 1'b0;
    end else begin
      valid_o <= boundary_o;
      if (boundary_o) begin
        cnt_q   <= '0;
        ratio_q <= ratio_i;
      end else begin
        cnt_q   <= cnt_next[CNT_W-1:0];
      end
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic signed [ACC_W-1:0] sum;
    assign sum = acc_q[ch] + ACC_W'(prod[ch]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        acc_q[ch] <= '0;
        out_q[ch] <= '0;
      end else if (boundary_o) begin
        acc_q[ch] <= '0;
        out_q[ch] <= sum;
      end else begin
        acc_q[ch] <= sum;
      end
    end

    assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      acc_q[ch][ACC_W-1] == acc_q[ch][ACC_W-2]);
  end

  assign sum_i_o = out_q[0];
  assign sum_q_o = out_q[1];

  assert_cnt_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ratio_q != '0) |-> (cnt_q < ratio_q));

  assert_valid_restart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (cnt_q == '0));

  assert_single_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ratio_q > 1) |=> !valid_o);

  assert_ratio_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(ratio_q));
endmodule

// File: rtl/lockin_iq_demod.sv
module lockin_iq_demod #(
  parameter int unsigned ADC_W    = 12,
  parameter int unsigned REF_W    = 16,
  parameter int unsigned PHASE_W  = 32,
  parameter int unsigned LUT_AW   = 10,
  parameter int unsigned ACC_W    = 56,
  parameter int unsigned CNT_W    = 32,
  parameter logic [PHASE_W-1:0] DEF_TUNE  = 33071248,
  parameter logic [CNT_W-1:0]   DEF_RATIO = 20000000
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [ADC_W-1:0] adc_i,
  input  logic [PHASE_W-1:0]      tune_word_i,
  input  logic [CNT_W-1:0]        dec_ratio_i,
  output logic signed [REF_W-1:0] dac_o,
  output logic signed [ACC_W-1:0] iq_i_o,
  output logic signed [ACC_W-1:0] iq_q_o,
  output logic                    iq_valid_o
);
  localparam int unsigned PROD_W = ADC_W + REF_W;

  logic                     boundary;
  logic signed [REF_W-1:0]  cos_r, sin_r;
  logic signed [PROD_W-1:0] prod_i, prod_q;

  lockin_nco #(
    .PHASE_W (PHASE_W),
    .LUT_AW  (LUT_AW),
    .REF_W   (REF_W),
    .DEF_TUNE(DEF_TUNE)
  ) i_nco (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (boundary),
    .tune_word_i(tune_word_i),
    .cos_o      (cos_r),
    .sin_o      (sin_r)
  );

  lockin_mixer #(
    .ADC_W (ADC_W),
    .REF_W (REF_W),
    .PROD_W(PROD_W)
  ) i_mixer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .adc_i   (adc_i),
    .cos_i   (cos_r),
    .sin_i   (sin_r),
    .dac_o   (dac_o),
    .prod_i_o(prod_i),
    .prod_q_o(prod_q)
  );

  lockin_dump #(
    .PROD_W   (PROD_W),
    .ACC_W    (ACC_W),
    .CNT_W    (CNT_W),
    .DEF_RATIO(DEF_RATIO)
  ) i_dump (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .prod_i_i  (prod_i),
    .prod_q_i  (prod_q),
    .ratio_i   (dec_ratio_i),
    .boundary_o(boundary),
    .sum_i_o   (iq_i_o),
    .sum_q_o   (iq_q_o),
    .valid_o   (iq_valid_o)
  );

  // reset leaves every output quiet
  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (dac_o == '0 && !iq_valid_o && iq_i_o == '0 && iq_q_o == '0));
endmodule

// File: tb/test_lockin_iq_demod.sv
module test_lockin_iq_demod;
  localparam int  TB_RATIO = 24;
  localparam logic [31:0] TB_TUNE = 32'd33071248;
  localparam time HALF = 10ns;

  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic signed [11:0] adc_s = '0;
  logic [31:0]        tune_s = TB_TUNE;
  logic [31:0]        ratio_s = TB_RATIO;
  logic signed [15:0] dac;
  logic signed [55:0] iq_i, iq_q;
  logic               iq_valid;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #HALF clk = ~clk;

  lockin_iq_demod #(.DEF_RATIO(32'(TB_RATIO)), .DEF_TUNE(TB_TUNE)) i_lockin_iq_demod (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .adc_i      (adc_s),
    .tune_word_i(tune_s),
    .dec_ratio_i(ratio_s),
    .dac_o      (dac),
    .iq_i_o     (iq_i),
    .iq_q_o     (iq_q),
    .iq_valid_o (iq_valid)
  );

  function automatic int tab(int k);
    return $rtoi(32767.0 * $sin(1.5707963267948966 * (real'(k) + 0.5) / 256.0));
  endfunction

  task automatic ref_of(input logic [31:0] ph, output int c, output int s);
    int a, qd, k;
    a  = int'(ph >> 22);
    qd = a >> 8;
    k  = a & 255;
    case (qd)
      0: begin s =  tab(k);       c =  tab(255 - k); end
      1: begin s =  tab(255 - k); c = -tab(k);       end
      2: begin s = -tab(k);       c = -tab(255 - k); end
      default: begin s = -tab(255 - k); c = tab(k); end
    endcase
  endtask

  task automatic check(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model, updated on each rising edge
  logic [31:0] m_phase = '0, m_tw = TB_TUNE;
  longint m_cnt = 0, m_ratio = TB_RATIO;
  int     m_cos1 = 0, m_sin1 = 0, m_adc1 = 0, m_dac = 0;
  longint m_pi = 0, m_pq = 0, m_acci = 0, m_accq = 0, m_outi = 0, m_outq = 0;
  bit     m_valid = 1'b0;

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_phase = '0; m_tw = TB_TUNE; m_cnt = 0; m_ratio = TB_RATIO;
      m_cos1 = 0; m_sin1 = 0; m_adc1 = 0; m_dac = 0;
      m_pi = 0; m_pq = 0; m_acci = 0; m_accq = 0; m_outi = 0; m_outq = 0; m_valid = 1'b0;
    end else begin
      bit bnd;
      int nc, ns;
      bnd = (m_cnt + 1) >= m_ratio;
      if (bnd) begin
        m_outi = m_acci + m_pi; m_outq = m_accq + m_pq;
        m_acci = 0; m_accq = 0; m_cnt = 0; m_valid = 1'b1;
      end else begin
        m_acci += m_pi; m_accq += m_pq; m_cnt++; m_valid = 1'b0;
      end
      m_pi  = longint'(m_adc1) * m_cos1;
      m_pq  = longint'(m_adc1) * m_sin1;
      m_dac = m_cos1;
      ref_of(m_phase, nc, ns);
      m_cos1 = nc; m_sin1 = ns;
      m_adc1 = int'(adc_s);
      m_phase = m_phase + m_tw;
      if (bnd) begin m_tw = tune_s; m_ratio = longint'(ratio_s); end
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (rst_ni && !finished) begin
      check("R2/R3/R4 dac", longint'(dac), longint'(m_dac));
      check("R6/R8/R9 valid", longint'(iq_valid), longint'(m_valid));
      if (m_valid) begin
        check("R5/R6/R7 sum I", longint'(iq_i), m_outi);
        check("R5/R6/R7 sum Q", longint'(iq_q), m_outq);
      end
    end
  end

  task automatic finish_run();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  task automatic drive(input int n, input int mode);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #2;
      case (mode)
        0: adc_s = 12'($urandom);
        1: adc_s = -12'sd2048;
        default: begin
          adc_s  = 12'($urandom);
          tune_s = $urandom;
        end
      endcase
    end
  endtask

  initial begin
    #(HALF * 2 * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: outputs quiet under reset
    check("R1 dac", longint'(dac), 0);
    check("R1 valid", longint'(iq_valid), 0);
    check("R1 sum I", longint'(iq_i), 0);
    check("R1 sum Q", longint'(iq_q), 0);
    #2 rst_ni = 1'b1;

    // R9 defaults: ratio inputs differ, first window still uses TB_RATIO
    ratio_s = 7;
    drive(TB_RATIO + 20, 0);

    // R7: full-scale negative input, quarter-cycle steps across all quadrants
    tune_s = 32'h4000_0000;
    ratio_s = 400;
    drive(900, 1);

    // R8: tuning word changes every clock, loads only at boundaries
    ratio_s = 17;
    drive(200, 2);

    // R6/R8: ratio 1 and 0 give back-to-back windows
    tune_s = TB_TUNE;
    ratio_s = 1;
    drive(30, 0);
    ratio_s = 0;
    drive(30, 0);

    // random ratios and tuning words
    for (int blk = 0; blk < 60; blk++) begin
      ratio_s = 1 + ($urandom % 40);
      tune_s  = $urandom;
      drive(25 + ($urandom % 30), 0);
    end
    ratio_s = 5;
    drive(100, 0);
    finish_run();
  end
endmodule